// File: doc/BRIEF.md
# Collapsing Out-of-Order Issue Queue

This block holds renamed integer instructions until their source operands are available and then sends them to execution. Up to four instructions enter per cycle through a four-lane dispatch port. Each instruction carries two source tags with ready bits, a destination tag, an opaque payload and a static pipe-class bit that selects the upper or the lower pipe. A broadcast of up to four physical destination tags per cycle marks matching sources as ready.

The queue is kept in age order by physical position. Entry 0 is always the oldest. Every cycle the arbiter scans from oldest to youngest. For each pipe class it sends the oldest ready instruction to that class's pipe in cluster 0 and the next one to the same pipe in cluster 1. This gives four issue ports. Issued entries vanish at the clock edge. The survivors slide toward entry 0, and the accepted dispatch group is appended behind them, so the queue never holds holes.

A dispatch group is taken whole or not at all. When the queue lacks room for every valid lane, a stall is raised and the renamer must hold the group.

Top module: `iq_collapse`

## Requirements
- R1: After reset the queue is empty: all four issue valids are 0 and the stall output is 0.
- R2: The stall output is 1 exactly when the number of valid dispatch lanes exceeds the free entries. Free entries are DEPTH minus the occupancy at the start of the cycle, so entries issuing in that cycle do not count as free. A stalled group is discarded in full.
- R3: An entry is eligible for issue only while both of its source ready bits are 1.
- R4: A wakeup tag sets the ready bit of every matching source. This covers stored entries and lanes being dispatched in the same cycle. The effect is visible in issue from the following cycle.
- R5: Issue port index = 2*cluster + pipe, where pipe is the dispatch bit disp_upper (1 = upper pipe, 0 = lower pipe). An instruction only ever leaves on a port of its own pipe class.
- R6: Within each pipe class, the oldest ready entry goes to the cluster-0 port and the second oldest to the cluster-1 port. Younger ready entries of that class wait. No port carries more than one instruction per cycle.
- R7: Age order: lane 0 of a dispatch group is older than lane 1, and so on up to lane 3. Every entry of an earlier group is older than every entry of a later group.
- R8: An issued entry is removed at the edge that ends its issue cycle and never issues again. The remaining entries keep their relative age order.
- R9: An instruction dispatched with both sources ready can appear on an issue port in the cycle right after the edge that wrote it.
- R10: The queue holds exactly DEPTH (20) entries. When it is full, any valid dispatch lane raises the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_v | input | LANES | Per-lane dispatch valid |
| disp_srca | input | LANES x TAG_W | First source tag per lane |
| disp_srcb | input | LANES x TAG_W | Second source tag per lane |
| disp_rdya | input | LANES | First source already ready |
| disp_rdyb | input | LANES | Second source already ready |
| disp_upper | input | LANES | Pipe class: 1 upper, 0 lower |
| disp_dst | input | LANES x TAG_W | Destination tag per lane |
| disp_pl | input | LANES x PL_W | Opaque payload per lane |
| disp_stall | output | 1 | Group rejected for lack of room |
| wake_v | input | WAKES | Wakeup tag valid |
| wake_tag | input | WAKES x TAG_W | Physical destination tags being produced |
| iss_v | output | 4 | Issue valid per port (2*cluster + pipe) |
| iss_dst | output | 4 x TAG_W | Destination tag on each issue port |
| iss_pl | output | 4 x PL_W | Payload on each issue port |

## Verification
A corrupted ready bit shows at the ports in the very next cycle. Either an instruction appears on a port before its producer tag was broadcast, or it never appears after the broadcast. A fault in compaction or age ordering shows within one cycle as a payload on the wrong port or a younger payload ahead of an older one. Such a fault can also show as the same payload issued twice, or as a payload that drops out of the stream without being issued. An off-by-one in the occupancy shows as a wrong stall value when the queue is near full. It also shows later as a lost or phantom instruction that breaks the expected issue sequence.

// File: rtl/iq_pkg.sv
package iq_pkg;
   localparam int N_CLUSTERS = 2;
   localparam int N_PIPES    = 2;
   localparam int N_PORTS    = N_CLUSTERS * N_PIPES;

   typedef enum logic {PIPE_LO = 1'b0, PIPE_HI = 1'b1} pipe_e;

   // issue port numbering: cluster selects the pair, pipe selects within it
   function automatic int port_index(input int cluster, input int pipe);
      return cluster * N_PIPES + pipe;
   endfunction
endpackage

// File: rtl/iq_wake.sv
module iq_wake #(
   parameter int TAG_W = 7,
   parameter int WAKES = 4
) (
   input  logic [TAG_W-1:0]            src_tag,
   input  logic                        rdy_in,
   input  logic [WAKES-1:0]            wake_v,
   input  logic [WAKES-1:0][TAG_W-1:0] wake_tag,
   output logic                        rdy_out
);
   generate
      if (WAKES < 1) begin : g_bad_wakes
         $error("iq_wake: WAKES must be at least 1");
      end
   endgenerate

   always_comb begin
      rdy_out = rdy_in;
      for (int w = 0; w < WAKES; w++) begin
         if (wake_v[w] && (wake_tag[w] == src_tag)) rdy_out = 1'b1;
      end
   end
endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
   parameter int DEPTH = 20,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] req,
   output logic             first_v,
   output logic [IDX_W-1:0] first_idx,
   output logic             second_v,
   output logic [IDX_W-1:0] second_idx,
   output logic [DEPTH-1:0] taken
);
   generate
      if (IDX_W != $clog2(DEPTH)) begin : g_bad_idx
         $error("iq_pick: IDX_W must equal clog2(DEPTH)");
      end
   endgenerate

   // scan from position 0 (oldest) upward, keep the first two requesters
   always_comb begin
      first_v    = 1'b0;
      second_v   = 1'b0;
      first_idx  = '0;
      second_idx = '0;
      taken      = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (req[i]) begin
            if (!first_v) begin
               first_v   = 1'b1;
               first_idx = IDX_W'(i);
               taken[i]  = 1'b1;
            end else if (!second_v) begin
               second_v   = 1'b1;
               second_idx = IDX_W'(i);
               taken[i]   = 1'b1;
            end
         end
      end
   end

   // second grant is always younger than the first one (R6)
   p_pick_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      second_v |-> (first_v && (second_idx > first_idx)));

   // the winners are requesters (R3 eligibility propagates through req)
   p_pick_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (taken & ~req) == '0);
endmodule

// File: rtl/iq_compact.sv
module iq_compact #(
   parameter int DEPTH = 20,
   parameter int LANES = 4,
   parameter int EW    = 40,
   parameter int CNT_W = 5,
   parameter int IDX_W = 5
) (
   input  logic [DEPTH-1:0][EW-1:0] old_q,
   input  logic [DEPTH-1:0]         keep,
   input  logic [LANES-1:0][EW-1:0] lane_q,
   input  logic [LANES-1:0]         lane_v,
   input  logic                     accept,
   output logic [DEPTH-1:0][EW-1:0] nxt_q,
   output logic [DEPTH-1:0]         nxt_v
);
   generate
      if (CNT_W != $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("iq_compact: CNT_W must equal clog2(DEPTH+1)");
      end
   endgenerate

   // survivors slide toward position 0 in order, new lanes land behind them
   always_comb begin
      logic [CNT_W-1:0] pos;
      nxt_q = '0;
      nxt_v = '0;
      pos   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (keep[i]) begin
            if (pos < CNT_W'(DEPTH)) begin
               nxt_q[pos[IDX_W-1:0]] = old_q[i];
               nxt_v[pos[IDX_W-1:0]] = 1'b1;
            end
            pos = pos + 1'b1;
         end
      end
      if (accept) begin
         for (int l = 0; l < LANES; l++) begin
            if (lane_v[l]) begin
               if (pos < CNT_W'(DEPTH)) begin
                  nxt_q[pos[IDX_W-1:0]] = lane_q[l];
                  nxt_v[pos[IDX_W-1:0]] = 1'b1;
               end
               pos = pos + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/iq_collapse.sv
module iq_collapse
   import iq_pkg::*;
#(
   parameter int DEPTH = 20,
   parameter int LANES = 4,
   parameter int WAKES = 4,
   parameter int TAG_W = 7,
   parameter int PL_W  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [LANES-1:0]              disp_v,
   input  logic [LANES-1:0][TAG_W-1:0]   disp_srca,
   input  logic [LANES-1:0][TAG_W-1:0]   disp_srcb,
   input  logic [LANES-1:0]              disp_rdya,
   input  logic [LANES-1:0]              disp_rdyb,
   input  logic [LANES-1:0]              disp_upper,
   input  logic [LANES-1:0][TAG_W-1:0]   disp_dst,
   input  logic [LANES-1:0][PL_W-1:0]    disp_pl,
   output logic                          disp_stall,
   input  logic [WAKES-1:0]              wake_v,
   input  logic [WAKES-1:0][TAG_W-1:0]   wake_tag,
   output logic [N_PORTS-1:0]            iss_v,
   output logic [N_PORTS-1:0][TAG_W-1:0] iss_dst,
   output logic [N_PORTS-1:0][PL_W-1:0]  iss_pl
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);

   typedef struct packed {
      logic [TAG_W-1:0] sa;
      logic [TAG_W-1:0] sb;
      logic [TAG_W-1:0] dst;
      logic             ra;
      logic             rb;
      logic             upper;
      logic [PL_W-1:0]  pl;
   } ent_t;

   localparam int EW = $bits(ent_t);

   generate
      if (LANES > DEPTH) begin : g_bad_lanes
         $error("iq_collapse: LANES must not exceed DEPTH");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("iq_collapse: DEPTH must be at least 2");
      end
      if (TAG_W < 1 || PL_W < 1) begin : g_bad_width
         $error("iq_collapse: TAG_W and PL_W must be positive");
      end
   endgenerate

   ent_t [DEPTH-1:0] q;
   logic [DEPTH-1:0] vld;
   ent_t [DEPTH-1:0] q_w;
   ent_t [LANES-1:0] ln_w;
   logic [DEPTH-1:0] rdy_vec;
   logic [DEPTH-1:0] hi_vec;
   logic [DEPTH-1:0] keep;
   logic [DEPTH-1:0][EW-1:0] nxt_q;
   logic [DEPTH-1:0] nxt_v;
   logic [CNT_W-1:0] occ;
   logic [CNT_W-1:0] free_cnt;
   logic [CNT_W-1:0] want_cnt;

   logic [N_PIPES-1:0][DEPTH-1:0] req;
   logic [N_PIPES-1:0][DEPTH-1:0] taken;
   logic [N_PIPES-1:0]            g0_v, g1_v;
   logic [N_PIPES-1:0][IDX_W-1:0] g0_idx, g1_idx;

   // occupancy and all-or-nothing admission
   always_comb begin
      occ      = CNT_W'($countones(vld));
      free_cnt = CNT_W'(DEPTH) - occ;
      want_cnt = CNT_W'($countones(disp_v));
   end
   assign disp_stall = (want_cnt > free_cnt);

   // stored entries: wakeup applied on the way to the next state
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         logic ra_w, rb_w;
         ent_t ew;
         iq_wake #(.TAG_W(TAG_W), .WAKES(WAKES)) u_wa (
            .src_tag(q[i].sa), .rdy_in(q[i].ra), .wake_v(wake_v),
            .wake_tag(wake_tag), .rdy_out(ra_w));
         iq_wake #(.TAG_W(TAG_W), .WAKES(WAKES)) u_wb (
            .src_tag(q[i].sb), .rdy_in(q[i].rb), .wake_v(wake_v),
            .wake_tag(wake_tag), .rdy_out(rb_w));
         always_comb begin
            ew    = q[i];
            ew.ra = ra_w;
            ew.rb = rb_w;
         end
         assign q_w[i]     = ew;
         assign rdy_vec[i] = q[i].ra & q[i].rb;
         assign hi_vec[i]  = q[i].upper;
      end

      // dispatch lanes: same-cycle wakeup folded in
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic ra_w, rb_w;
         ent_t lw;
         iq_wake #(.TAG_W(TAG_W), .WAKES(WAKES)) u_wa (
            .src_tag(disp_srca[l]), .rdy_in(disp_rdya[l]), .wake_v(wake_v),
            .wake_tag(wake_tag), .rdy_out(ra_w));
         iq_wake #(.TAG_W(TAG_W), .WAKES(WAKES)) u_wb (
            .src_tag(disp_srcb[l]), .rdy_in(disp_rdyb[l]), .wake_v(wake_v),
            .wake_tag(wake_tag), .rdy_out(rb_w));
         always_comb begin
            lw.sa    = disp_srca[l];
            lw.sb    = disp_srcb[l];
            lw.dst   = disp_dst[l];
            lw.ra    = ra_w;
            lw.rb    = rb_w;
            lw.upper = disp_upper[l];
            lw.pl    = disp_pl[l];
         end
         assign ln_w[l] = lw;
      end

      // one oldest-first picker per pipe class; first winner to cluster 0
      for (genvar p = 0; p < N_PIPES; p++) begin : g_pipe
         localparam int PORT_C0 = port_index(0, p);
         localparam int PORT_C1 = port_index(1, p);
         if (p == int'(PIPE_HI)) begin : g_hi
            assign req[p] = vld & rdy_vec & hi_vec;
         end else begin : g_lo
            assign req[p] = vld & rdy_vec & ~hi_vec;
         end
         iq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
            .clk(clk), .rst_n(rst_n), .req(req[p]),
            .first_v(g0_v[p]), .first_idx(g0_idx[p]),
            .second_v(g1_v[p]), .second_idx(g1_idx[p]),
            .taken(taken[p]));
         assign iss_v[PORT_C0]   = g0_v[p];
         assign iss_dst[PORT_C0] = q[g0_idx[p]].dst;
         assign iss_pl[PORT_C0]  = q[g0_idx[p]].pl;
         assign iss_v[PORT_C1]   = g1_v[p];
         assign iss_dst[PORT_C1] = q[g1_idx[p]].dst;
         assign iss_pl[PORT_C1]  = q[g1_idx[p]].pl;

         // a port only carries its own pipe class (R5)
         p_port_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
            iss_v[PORT_C0] |-> (q[g0_idx[p]].upper == 1'(p)) && vld[g0_idx[p]]);
         // issued entries had both operands ready (R3)
         p_ready_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
            iss_v[PORT_C1] |-> (q[g1_idx[p]].ra && q[g1_idx[p]].rb));
      end
   endgenerate

   always_comb begin
      logic [DEPTH-1:0] any_taken;
      any_taken = '0;
      for (int p = 0; p < N_PIPES; p++) any_taken = any_taken | taken[p];
      keep = vld & ~any_taken;
   end

   iq_compact #(.DEPTH(DEPTH), .LANES(LANES), .EW(EW), .CNT_W(CNT_W),
                .IDX_W(IDX_W)) u_compact (
      .old_q(q_w), .keep(keep), .lane_q(ln_w), .lane_v(disp_v),
      .accept(!disp_stall), .nxt_q(nxt_q), .nxt_v(nxt_v));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         q   <= '0;
      end else begin
         vld <= nxt_v;
         q   <= nxt_q;
      end
   end

   // valid entries always form a solid block from position 0 (R8)
   p_no_holes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((vld + 1'b1) & vld) == '0);

   // a stalled group never grows the queue (R2)
   p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stall |=> ($countones(vld) <= $past($countones(vld))));

   // occupancy tracks removals and accepted lanes, never above DEPTH (R10)
   p_occ_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_stall |=> ($countones(vld) == $past($countones(vld))
                       - $past($countones(vld & ~keep))
                       + $past($countones(disp_v))));
endmodule

// File: tb/iq_collapse_tb.sv
module iq_collapse_tb;
   localparam int DEPTH = 20;
   localparam int LANES = 4;
   localparam int WAKES = 4;
   localparam int TAG_W = 7;
   localparam int PL_W  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LANES-1:0]            disp_v;
   logic [LANES-1:0][TAG_W-1:0] disp_srca, disp_srcb, disp_dst;
   logic [LANES-1:0]            disp_rdya, disp_rdyb, disp_upper;
   logic [LANES-1:0][PL_W-1:0]  disp_pl;
   logic                        disp_stall;
   logic [WAKES-1:0]            wake_v;
   logic [WAKES-1:0][TAG_W-1:0] wake_tag;
   logic [3:0]                  iss_v;
   logic [3:0][TAG_W-1:0]       iss_dst;
   logic [3:0][PL_W-1:0]        iss_pl;

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct {
      logic [TAG_W-1:0] sa, sb;
      logic ra, rb, up;
      logic [PL_W-1:0] id;
   } m_t;
   m_t model[$];   // scoreboard: expected contents in age order

   always #5 clk = ~clk;

   iq_collapse u_dut (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_in();
      disp_v = '0; disp_srca = '0; disp_srcb = '0; disp_dst = '0;
      disp_rdya = '0; disp_rdyb = '0; disp_upper = '0; disp_pl = '0;
      wake_v = '0; wake_tag = '0;
   endtask

   // driver: present one lane
   task automatic put(input int l, input logic [TAG_W-1:0] sa, input logic ra,
                      input logic [TAG_W-1:0] sb, input logic rb,
                      input logic up, input logic [PL_W-1:0] id);
      disp_v[l] = 1'b1; disp_srca[l] = sa; disp_rdya[l] = ra;
      disp_srcb[l] = sb; disp_rdyb[l] = rb; disp_upper[l] = up;
      disp_pl[l] = id; disp_dst[l] = id[TAG_W-1:0];
   endtask

   task automatic wake(input int w, input logic [TAG_W-1:0] t);
      wake_v[w] = 1'b1; wake_tag[w] = t;
   endtask

   function automatic bit woke(input logic [TAG_W-1:0] t);
      for (int w = 0; w < WAKES; w++)
         if (wake_v[w] && wake_tag[w] == t) return 1'b1;
      return 1'b0;
   endfunction

   // monitor + scoreboard update for one cycle; inputs already applied
   task automatic tick();
      bit exp_stall;
      logic [3:0] ev;
      logic [3:0][PL_W-1:0] epl;
      int cnt [2];
      bit gr [$];
      m_t nq [$];
      m_t e;
      #1;
      exp_stall = $countones(disp_v) > (DEPTH - model.size());
      chk(disp_stall == exp_stall, "R2 stall", disp_stall, exp_stall);
      ev = '0; epl = '0; cnt[0] = 0; cnt[1] = 0;
      foreach (model[i]) begin
         gr.push_back(1'b0);
         if (model[i].ra && model[i].rb) begin
            int c = int'(model[i].up);
            if (cnt[c] < 2) begin
               int port = cnt[c] * 2 + c;   // R5: port = 2*cluster + pipe
               ev[port] = 1'b1; epl[port] = model[i].id;
               gr[i] = 1'b1; cnt[c]++;
            end
         end
      end
      for (int p = 0; p < 4; p++) begin
         chk(iss_v[p] == ev[p], "R6 issue valid", iss_v[p], ev[p]);
         if (ev[p] && iss_v[p]) begin
            chk(iss_pl[p] == epl[p], "R6 issue payload", iss_pl[p], epl[p]);
            chk(iss_dst[p] == epl[p][TAG_W-1:0], "R6 issue dst", iss_dst[p],
                epl[p][TAG_W-1:0]);
         end
      end
      foreach (model[i]) begin
         if (!gr[i]) begin
            e = model[i];
            if (woke(e.sa)) e.ra = 1'b1;
            if (woke(e.sb)) e.rb = 1'b1;
            nq.push_back(e);
         end
      end
      if (!exp_stall) begin
         for (int l = 0; l < LANES; l++) begin
            if (disp_v[l]) begin
               e.sa = disp_srca[l]; e.sb = disp_srcb[l];
               e.ra = disp_rdya[l] | woke(disp_srca[l]);
               e.rb = disp_rdyb[l] | woke(disp_srcb[l]);
               e.up = disp_upper[l]; e.id = disp_pl[l];
               nq.push_back(e);
            end
         end
      end
      model = nq;
      @(posedge clk);
      @(negedge clk);
      clear_in();
      #1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [PL_W-1:0] id;
      clear_in();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty after reset
      chk(iss_v == 4'b0000, "R1 issue idle", iss_v, 0);
      chk(disp_stall == 1'b0, "R1 stall low", disp_stall, 0);

      // R9 and R5: four ready lanes, mixed pipe classes
      put(0, 7'd1, 1, 7'd2, 1, 0, 16'd1);
      put(1, 7'd1, 1, 7'd2, 1, 1, 16'd2);
      put(2, 7'd1, 1, 7'd2, 1, 0, 16'd3);
      put(3, 7'd1, 1, 7'd2, 1, 1, 16'd4);
      tick();
      chk(iss_v == 4'b1111, "R9 issue next cycle", iss_v, 4'hf);
      chk(iss_pl[1] == 16'd2, "R5 cluster0 upper port", iss_pl[1], 2);
      chk(iss_pl[2] == 16'd3, "R5 cluster1 lower port", iss_pl[2], 3);
      tick();
      chk(iss_v == 4'b0000, "R8 issued entries removed", iss_v, 0);

      // R3 and R4: operands wait for wakeup
      put(0, 7'd5, 0, 7'd2, 1, 0, 16'd10);
      put(1, 7'd6, 0, 7'd2, 1, 1, 16'd11);
      tick();
      chk(iss_v == 4'b0000, "R3 not ready held", iss_v, 0);
      tick();
      chk(iss_v == 4'b0000, "R3 still held", iss_v, 0);
      wake(0, 7'd5);
      tick();
      chk(iss_v == 4'b0001 && iss_pl[0] == 16'd10, "R4 stored wake", iss_pl[0], 10);
      wake(2, 7'd6);
      tick();
      chk(iss_v == 4'b0010 && iss_pl[1] == 16'd11, "R4 second wake", iss_pl[1], 11);
      put(0, 7'd9, 0, 7'd2, 1, 0, 16'd12);
      wake(1, 7'd9);
      tick();
      chk(iss_v[0] && iss_pl[0] == 16'd12, "R4 same-cycle dispatch wake", iss_pl[0], 12);
      tick();

      // R7 and R6: three lower ready entries, two clusters
      put(0, 7'd1, 1, 7'd1, 1, 0, 16'd20);
      put(1, 7'd1, 1, 7'd1, 1, 0, 16'd21);
      put(2, 7'd1, 1, 7'd1, 1, 0, 16'd22);
      tick();
      chk(iss_v == 4'b0101, "R6 two lower grants", iss_v, 4'b0101);
      chk(iss_pl[0] == 16'd20 && iss_pl[2] == 16'd21, "R7 lane age", iss_pl[0], 20);
      tick();
      chk(iss_v == 4'b0001 && iss_pl[0] == 16'd22, "R6 youngest waits", iss_pl[0], 22);
      tick();

      // R10 and R2: fill to capacity with blocked entries
      for (int g = 0; g < 5; g++) begin
         for (int l = 0; l < 4; l++)
            put(l, 7'd100, 0, 7'd1, 1, 1'(l), 16'(30 + g * 4 + l));
         tick();
      end
      put(0, 7'd1, 1, 7'd1, 1, 0, 16'd50);
      #1;
      chk(disp_stall == 1'b1, "R10 full queue stalls", disp_stall, 1);
      tick();
      tick();
      chk(iss_v == 4'b0000, "R2 stalled group dropped", iss_v, 0);
      wake(3, 7'd100);
      tick();
      chk(iss_pl[0] == 16'd30 && iss_pl[3] == 16'd33, "R8 order after wake",
          iss_pl[0], 30);
      for (int k = 0; k < 6; k++) tick();

      // random traffic against the scoreboard
      id = 16'd100;
      for (int c = 0; c < 3000; c++) begin
         for (int l = 0; l < LANES; l++) begin
            if ($urandom_range(1, 0) == 1) begin
               put(l, 7'($urandom_range(15, 0)), 1'($urandom_range(2, 0) != 0),
                   7'($urandom_range(15, 0)), 1'($urandom_range(2, 0) != 0),
                   1'($urandom_range(1, 0)), id);
               id++;
            end
         end
         for (int w = 0; w < WAKES; w++)
            if ($urandom_range(1, 0) == 1) wake(w, 7'($urandom_range(15, 0)));
         tick();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule